// File: doc/BRIEF.md
# Peripheral Domain Access Checker

This block sits between the bus masters of a subsystem and its peripherals and decides whether each peripheral access may proceed. Every master is tied to one of four access domains through a small per-master table. Every peripheral has a policy word that gives each domain its own read-enable and write-enable bit. The policy word also has a flag saying that accesses must be arbitrated through a hardware semaphore. Both tables are filled through a simple register-write port. Each entry has a lock bit. Once the lock bit is set, the entry keeps its value until the next reset.

The verdict is combinational. In the cycle an access is presented, the block looks up the master's domain, selects the permission bit for that domain and access type, and drives either grant or deny. The semaphore-required indication is driven in the same cycle as the verdict. A denied access also raises a registered violation pulse one cycle later. A master or peripheral index beyond the configured count is always denied.

Top module: `periph_domain_guard`

## Requirements
- R1: After reset every master entry holds domain 0 and is unlocked, so every master is checked as domain 0 and accepts new assignments.
- R2: After reset every peripheral policy grants read and write to all four domains, with lock clear and semaphore-required clear.
- R3: A config write with `cfg_tgt_i`=0 to an in-range, unlocked master index takes effect from the next cycle. The master's domain is taken from `cfg_data_i[1:0]`, and `cfg_data_i[15]` becomes its lock bit.
- R4: A config write with `cfg_tgt_i`=1 to an in-range, unlocked peripheral index loads the permission byte from `cfg_data_i[7:0]`. For domain d, bit 2d enables write and bit 2d+1 enables read. `cfg_data_i[14]` is the semaphore-required flag and `cfg_data_i[15]` is the lock bit.
- R5: A valid access is granted exactly when the permission bit for the master's domain and the access type is set. Otherwise it is denied. Grant and deny are never both high, and neither is high without `acc_valid_i`.
- R6: `viol_o` is high for exactly one cycle in the cycle after each cycle in which a valid access is denied.
- R7: `sem_req_o` is high together with the verdict whenever the addressed in-range peripheral has its semaphore-required flag set.
- R8: Once a master entry is locked, later writes to it are ignored until reset.
- R9: Once a peripheral policy is locked, later writes to it are ignored until reset.
- R10: An access whose master index or peripheral index is at or above the configured count is denied. Such an access never raises `sem_req_o` because of an out-of-range peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_tgt_i | input | 1 | Write target: 0 master table, 1 peripheral policy table |
| cfg_idx_i | input | CIDX_W | Entry index for the config write |
| cfg_data_i | input | 16 | Config write data |
| acc_valid_i | input | 1 | Access request present |
| acc_master_i | input | MIDX_W | Requesting master index |
| acc_periph_i | input | PIDX_W | Target peripheral index |
| acc_write_i | input | 1 | 1 for write access, 0 for read |
| acc_grant_o | output | 1 | Access permitted |
| acc_deny_o | output | 1 | Access refused |
| sem_req_o | output | 1 | Target requires semaphore arbitration |
| viol_o | output | 1 | One-cycle pulse after a denied access |

## Verification
The assertions assume that the access inputs are held stable over a cycle. They also assume the configuration port uses only the listed data bits, and that the tables only change through config writes or reset. The stimulus changes inputs only on the falling clock edge. It mixes directed sequences with pseudo-random traffic. Lock bits are set rarely in that traffic, and reset is re-applied every few hundred cycles, so unlocked and locked tables both stay in play. Index ranges are drawn over the whole field width so that out-of-range masters and peripherals appear regularly.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  localparam int unsigned NUM_DOM  = 4;
  localparam int unsigned DOM_W    = 2;
  localparam int unsigned PERM_W   = 2 * NUM_DOM;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned LOCK_BIT = 15;
  localparam int unsigned SEM_BIT  = 14;

  typedef enum logic {
    TGT_MASTER = 1'b0,
    TGT_PERIPH = 1'b1
  } cfg_tgt_e;

  typedef struct packed {
    logic             lock;
    logic [DOM_W-1:0] dom;
  } mst_ent_t;

  typedef struct packed {
    logic              lock;
    logic              sem;
    logic [PERM_W-1:0] perm;
  } pol_ent_t;

  localparam mst_ent_t MST_RST = '{lock: 1'b0, dom: '0};
  localparam pol_ent_t POL_RST = '{lock: 1'b0, sem: 1'b0, perm: '1};
endpackage

// File: rtl/pdg_master_table.sv
module pdg_master_table
  import pdg_pkg::*;
#(
  parameter int unsigned N_ENT = 6,
  parameter int unsigned WR_W  = 4,
  parameter int unsigned RD_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WR_W-1:0]  wr_idx_i,
  input  mst_ent_t         wr_ent_i,
  input  logic [RD_W-1:0]  rd_idx_i,
  output logic [DOM_W-1:0] rd_dom_o,
  output logic             rd_hit_o
);
  mst_ent_t ent_q [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam logic [WR_W-1:0] MY_IDX = WR_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[i] <= MST_RST;
      else if (wr_en_i && wr_idx_i == MY_IDX && !ent_q[i].lock) ent_q[i] <= wr_ent_i;
    end

    assert_mst_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_q[i].lock |=> $stable(ent_q[i]));
  end

  always_comb begin
    rd_dom_o = '0;
    for (int i = 0; i < N_ENT; i++)
      if ({1'b0, rd_idx_i} == (RD_W+1)'(i)) rd_dom_o = ent_q[i].dom;
  end
  assign rd_hit_o = {1'b0, rd_idx_i} < (RD_W+1)'(N_ENT);
endmodule

// File: rtl/pdg_policy_table.sv
module pdg_policy_table
  import pdg_pkg::*;
#(
  parameter int unsigned N_ENT = 12,
  parameter int unsigned WR_W  = 4,
  parameter int unsigned RD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WR_W-1:0]   wr_idx_i,
  input  pol_ent_t          wr_ent_i,
  input  logic [RD_W-1:0]   rd_idx_i,
  output logic [PERM_W-1:0] rd_perm_o,
  output logic              rd_sem_o,
  output logic              rd_hit_o
);
  pol_ent_t ent_q [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam logic [WR_W-1:0] MY_IDX = WR_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[i] <= POL_RST;
      else if (wr_en_i && wr_idx_i == MY_IDX && !ent_q[i].lock) ent_q[i] <= wr_ent_i;
    end

    assert_pol_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_q[i].lock |=> $stable(ent_q[i]));
  end

  always_comb begin
    rd_perm_o = '0;
    rd_sem_o  = 1'b0;
    for (int i = 0; i < N_ENT; i++)
      if ({1'b0, rd_idx_i} == (RD_W+1)'(i)) begin
        rd_perm_o = ent_q[i].perm;
        rd_sem_o  = ent_q[i].sem;
      end
  end
  assign rd_hit_o = {1'b0, rd_idx_i} < (RD_W+1)'(N_ENT);
endmodule

// File: rtl/pdg_verdict.sv
module pdg_verdict
  import pdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              mst_hit_i,
  input  logic [DOM_W-1:0]  dom_i,
  input  logic              pol_hit_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic              sem_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic              sem_req_o,
  output logic              viol_o
);
  logic perm_bit;
  logic viol_q;

  // bit 2d = write enable, bit 2d+1 = read enable
  assign perm_bit  = perm_i[{dom_i, ~write_i}];
  assign grant_o   = valid_i && mst_hit_i && pol_hit_i && perm_bit;
  assign deny_o    = valid_i && !grant_o;
  assign sem_req_o = valid_i && pol_hit_i && sem_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= deny_o;
  end
  assign viol_o = viol_q;

  assert_verdict_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o) && ((grant_o || deny_o) == valid_i));
  assert_viol_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |=> viol_o);
  assert_viol_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deny_o |=> !viol_o);
  assert_oor_deny_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (!mst_hit_i || !pol_hit_i)) |-> deny_o);
  assert_sem_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sem_req_o |-> (valid_i && pol_hit_i));
endmodule

// File: rtl/periph_domain_guard.sv
module periph_domain_guard
  import pdg_pkg::*;
#(
  parameter int unsigned N_MASTERS = 6,
  parameter int unsigned N_PERIPHS = 12,
  parameter int unsigned MIDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  parameter int unsigned PIDX_W    = (N_PERIPHS > 1) ? $clog2(N_PERIPHS) : 1,
  parameter int unsigned CIDX_W    = (MIDX_W > PIDX_W) ? MIDX_W : PIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_tgt_i,
  input  logic [CIDX_W-1:0] cfg_idx_i,
  input  logic [15:0]       cfg_data_i,
  input  logic              acc_valid_i,
  input  logic [MIDX_W-1:0] acc_master_i,
  input  logic [PIDX_W-1:0] acc_periph_i,
  input  logic              acc_write_i,
  output logic              acc_grant_o,
  output logic              acc_deny_o,
  output logic              sem_req_o,
  output logic              viol_o
);
  mst_ent_t          mst_wr;
  pol_ent_t          pol_wr;
  logic              mst_we, pol_we;
  logic [DOM_W-1:0]  dom;
  logic              mst_hit, pol_hit, pol_sem;
  logic [PERM_W-1:0] pol_perm;
  logic              unused_cfg;

  assign mst_we     = cfg_we_i && (cfg_tgt_i == TGT_MASTER);
  assign pol_we     = cfg_we_i && (cfg_tgt_i == TGT_PERIPH);
  assign mst_wr     = '{lock: cfg_data_i[LOCK_BIT], dom: cfg_data_i[DOM_W-1:0]};
  assign pol_wr     = '{lock: cfg_data_i[LOCK_BIT], sem: cfg_data_i[SEM_BIT],
                        perm: cfg_data_i[PERM_W-1:0]};
  assign unused_cfg = ^cfg_data_i[SEM_BIT-1:PERM_W];

  pdg_master_table #(.N_ENT(N_MASTERS), .WR_W(CIDX_W), .RD_W(MIDX_W)) u_mst (
    .clk_i, .rst_ni,
    .wr_en_i (mst_we),
    .wr_idx_i(cfg_idx_i),
    .wr_ent_i(mst_wr),
    .rd_idx_i(acc_master_i),
    .rd_dom_o(dom),
    .rd_hit_o(mst_hit)
  );

  pdg_policy_table #(.N_ENT(N_PERIPHS), .WR_W(CIDX_W), .RD_W(PIDX_W)) u_pol (
    .clk_i, .rst_ni,
    .wr_en_i  (pol_we),
    .wr_idx_i (cfg_idx_i),
    .wr_ent_i (pol_wr),
    .rd_idx_i (acc_periph_i),
    .rd_perm_o(pol_perm),
    .rd_sem_o (pol_sem),
    .rd_hit_o (pol_hit)
  );

  pdg_verdict u_vrd (
    .clk_i, .rst_ni,
    .valid_i  (acc_valid_i),
    .write_i  (acc_write_i),
    .mst_hit_i(mst_hit),
    .dom_i    (dom),
    .pol_hit_i(pol_hit),
    .perm_i   (pol_perm),
    .sem_i    (pol_sem),
    .grant_o  (acc_grant_o),
    .deny_o   (acc_deny_o),
    .sem_req_o(sem_req_o),
    .viol_o   (viol_o)
  );
endmodule

// File: tb/periph_domain_guard_test.sv
module periph_domain_guard_test;
  localparam int NM = 6, NP = 12, MW = 3, PW = 4, CW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_we = 0, cfg_tgt = 0, acc_valid = 0, acc_write = 0;
  logic [CW-1:0] cfg_idx = '0;
  logic [15:0]   cfg_data = '0;
  logic [MW-1:0] acc_master = '0;
  logic [PW-1:0] acc_periph = '0;
  logic          grant, deny, semr, viol;

  periph_domain_guard #(.N_MASTERS(NM), .N_PERIPHS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_tgt_i(cfg_tgt), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .acc_valid_i(acc_valid), .acc_master_i(acc_master), .acc_periph_i(acc_periph),
    .acc_write_i(acc_write),
    .acc_grant_o(grant), .acc_deny_o(deny), .sem_req_o(semr), .viol_o(viol)
  );

  int m_dom[NM]; bit m_lck[NM];
  int p_perm[NP]; bit p_sem[NP]; bit p_lck[NP];
  bit prev_deny;
  int checks = 0, fails = 0;

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NM; i++) begin m_dom[i] = 0; m_lck[i] = 0; end
    for (int i = 0; i < NP; i++) begin p_perm[i] = 8'hFF; p_sem[i] = 0; p_lck[i] = 0; end
    prev_deny = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; cfg_we = 0; acc_valid = 0;
    repeat (2) @(negedge clk);
    chk("R6", viol, 1'b0, "viol in reset");
    model_reset();
    rst_ni = 1;
  endtask

  task automatic step(bit we, bit tgt, int idx, int data, bit v, int m, int p, bit w, string tag);
    bit mh, ph, ok, eg, ed, es;
    @(negedge clk);
    cfg_we = we; cfg_tgt = tgt; cfg_idx = CW'(idx); cfg_data = 16'(data);
    acc_valid = v; acc_master = MW'(m); acc_periph = PW'(p); acc_write = w;
    #2;
    mh = m < NM; ph = p < NP;
    ok = v && mh && ph && (((p_perm[p % NP] >> (2 * m_dom[m % NM] + (w ? 0 : 1))) & 1) == 1);
    eg = ok; ed = v && !ok; es = v && ph && p_sem[p % NP];
    chk((v && (!mh || !ph)) ? "R10" : tag, grant, eg, "grant");
    chk((v && (!mh || !ph)) ? "R10" : "R5", deny, ed, "deny");
    chk("R7", semr, es, "sem_req");
    chk("R6", viol, prev_deny, "viol");
    @(posedge clk);
    prev_deny = ed;
    if (we && !tgt && idx < NM && !m_lck[idx]) begin
      m_dom[idx] = data & 3; m_lck[idx] = (data >> 15) & 1;
    end
    if (we && tgt && idx < NP && !p_lck[idx]) begin
      p_perm[idx] = data & 8'hFF; p_sem[idx] = (data >> 14) & 1; p_lck[idx] = (data >> 15) & 1;
    end
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 R2: defaults grant all, no semaphore
    step(0, 0, 0, 0, 1, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 5, 11, 1, "R2");
    step(0, 0, 0, 0, 1, 3, 6, 0, "R2");
    // R3 R4: master 2 -> domain 3, periph 5 read-only for domain 3 (bit 7)
    step(1, 0, 2, 3, 0, 0, 0, 0, "R3");
    step(1, 1, 5, 16'h0080, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 2, 5, 0, "R3");
    step(0, 0, 0, 0, 1, 2, 5, 1, "R4");
    step(0, 0, 0, 0, 1, 0, 5, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R4: domain 0 write-only (bit 0)
    step(1, 1, 4, 16'h0001, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 1, 4, 1, "R4");
    step(0, 0, 0, 0, 1, 1, 4, 0, "R4");
    // R7
    step(1, 1, 7, 16'h40FF, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 3, 7, 0, "R7");
    step(0, 0, 0, 0, 1, 7, 7, 0, "R7");
    // R8: lock master 1 in domain 1, then try to move it
    step(1, 0, 1, 16'h8001, 0, 0, 0, 0, "R8");
    step(1, 0, 1, 16'h0002, 0, 0, 0, 0, "R8");
    step(1, 1, 8, 16'h000C, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 1, 8, 0, "R8");
    step(0, 0, 0, 0, 1, 1, 8, 1, "R8");
    // R9: lock periph 3 to domain 0 only, then try to open it
    step(1, 1, 3, 16'h8003, 0, 0, 0, 0, "R9");
    step(1, 1, 3, 16'h40FF, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 1, 3, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 3, 1, "R9");
    // R10
    step(0, 0, 0, 0, 1, 6, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 7, 0, 1, "R10");
    step(0, 0, 0, 0, 1, 0, 12, 0, "R10");
    step(0, 0, 0, 0, 1, 0, 15, 1, "R10");
    // R1: reset clears locks
    do_reset();
    step(1, 0, 1, 2, 1, 1, 3, 0, "R1");
    step(0, 0, 0, 0, 1, 1, 3, 1, "R1");
    // pseudo-random traffic, R4 R5
    for (int n = 0; n < 4000; n++) begin
      int d;
      if (n % 500 == 499) do_reset();
      d = $urandom & 16'h40FF;
      if (($urandom & 15) == 0) d |= 16'h8000;
      step(($urandom & 1) == 1, ($urandom & 1) == 1, $urandom % 16, d,
           ($urandom & 3) != 0, $urandom % 8, $urandom % 16, ($urandom & 1) == 1, "R4");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule